// File: doc/BRIEF.md
# Component-Split Digital Video Capture Port

This block takes in an 8-bit digital video stream in the ITU-R BT.656 format, in which the synchronisation is carried in-band as timing reference codes. It follows those codes to know when a line of active picture begins and ends, and which field and blanking region the stream is in. It then splits the interleaved 4:2:2 samples into three separate stores: one for luma (Y) and one each for the two colour-difference components (Cb and Cr). The luma store holds twice as many samples as either chroma store, because a 4:2:2 line carries one Cb and one Cr for every two Y samples. A downstream consumer, such as a DMA engine, drains each store on its own through a show-ahead read port with a fill level and an empty flag.

The port has two configurations, chosen by a static mode input that is changed only while reset is asserted. In single-channel mode only byte lane A is used, and channel A owns the full capacity of every store. In dual-channel mode a second byte lane B feeds an independent channel B, and each store is split in half, with one half for each channel. For each channel the block reports the current field, vertical blanking and whether a line is being captured. It also keeps a sticky overflow flag that records samples lost to a full store.

Top module: `vcap_port`

## Requirements
- R1: A timing reference code is the four bytes 0xFF, 0x00, 0x00, XY, in that order. In XY, bit 6 is the field bit F, bit 5 is the vertical blanking bit V, and bit 4 is H (H=1 marks end of active video, H=0 marks start of active video). The protection bits 3..0 are not checked.
- R2: Bytes are stored only from the byte after a start-of-active code with V=0 up to the end of that line. Bytes on lines whose start code has V=1, and all bytes outside active video, are discarded. `line_active` is 1 exactly while a channel is capturing.
- R3: Within active video the bytes are routed in the repeating order Cb, Y, Cr, Y. The order restarts at Cb after every start-of-active code.
- R4: Each store is a first-in first-out queue per channel. `*_rd_data` shows the oldest sample while `*_empty` is 0. A pulse on `*_rd_en` removes that sample. `*_level` gives the number of samples held. A read of an empty queue has no effect.
- R5: In single-channel mode, channel A holds up to `Y_DEPTH` Y samples and `Y_DEPTH/2` samples each of Cb and Cr.
- R6: In dual-channel mode, lane B feeds channel B. Each channel holds up to `Y_DEPTH/2` Y samples and `Y_DEPTH/4` samples each of Cb and Cr, and the two channels fill, drain and overflow independently.
- R7: A sample that arrives for a full queue is dropped, and the channel's `ovf` bit is set and held. A pulse on that channel's `ovf_clr` bit clears it. A new drop in the same cycle as the clear wins.
- R8: `field` and `vblank` hold the F and V bits of the last timing reference code the channel received.
- R9: In single-channel mode lane B is ignored: channel B's queues stay empty and its status outputs stay 0.
- R10: A byte 0xFF during active video is not stored and ends capture for the rest of that line.
- R11: After a synchronous active-high reset, all queues are empty with level 0, and `ovf`, `field`, `vblank` and `line_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel byte clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1 selects dual-channel mode; change only during reset |
| din_a | input | 8 | Byte lane A (channel A) |
| din_b | input | 8 | Byte lane B (channel B, dual mode only) |
| y_rd_en | input | 2 | Luma read strobe, bit per channel |
| cb_rd_en | input | 2 | Cb read strobe, bit per channel |
| cr_rd_en | input | 2 | Cr read strobe, bit per channel |
| y_rd_data | output | 16 | Luma head sample, byte per channel (channel A low) |
| cb_rd_data | output | 16 | Cb head sample, byte per channel |
| cr_rd_data | output | 16 | Cr head sample, byte per channel |
| y_level | output | 2*YLW | Luma fill level per channel, YLW = clog2(Y_DEPTH+1) |
| cb_level | output | 2*CLW | Cb fill level per channel, CLW = clog2(Y_DEPTH/2+1) |
| cr_level | output | 2*CLW | Cr fill level per channel |
| y_empty | output | 2 | Luma empty flag per channel |
| cb_empty | output | 2 | Cb empty flag per channel |
| cr_empty | output | 2 | Cr empty flag per channel |
| ovf | output | 2 | Sticky overflow flag per channel |
| ovf_clr | input | 2 | Overflow clear pulse per channel |
| field | output | 2 | Last received F bit per channel |
| vblank | output | 2 | Last received V bit per channel |
| line_active | output | 2 | Channel is capturing the current line |

## Verification
The bench builds the port with `Y_DEPTH` = 8, so channel A's chroma queues hold 4 samples in single mode and only 2 in dual mode. With such small queues, one short line of a few dozen bytes is enough to fill every queue exactly to capacity and then overflow it. That brings the capacity split of both modes, the drop-on-full rule and the sticky flag with its per-channel clear within reach. The same lines also cover blanked lines, an early 0xFF inside active video, and lane B being ignored in single mode.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    localparam logic [7:0] SYNC_HI = 8'hFF;
    localparam logic [7:0] SYNC_LO = 8'h00;

    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        COMP_Y  = 2'd0,
        COMP_CB = 2'd1,
        COMP_CR = 2'd2
    } comp_e;

    typedef enum logic [1:0] {
        PRE_IDLE = 2'd0,
        PRE_HI   = 2'd1,
        PRE_LO1  = 2'd2,
        PRE_LO2  = 2'd3
    } pre_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trc_t;

    function automatic trc_t decode_trc(input logic [7:0] b);
        trc_t t;
        t.f = b[6];
        t.v = b[5];
        t.h = b[4];
        return t;
    endfunction

    function automatic comp_e phase_comp(input phase_e p);
        case (p)
            PH_CB:   return COMP_CB;
            PH_CR:   return COMP_CR;
            default: return COMP_Y;
        endcase
    endfunction

endpackage

// File: rtl/vcap_lane_parser.sv
module vcap_lane_parser
    import vcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [7:0] din,
    output logic       wr_en,
    output comp_e      wr_comp,
    output logic [7:0] wr_data,
    output logic       field,
    output logic       vblank,
    output logic       active
);

    pre_e   pre_q;
    phase_e phase_q;
    trc_t   trc;

    assign trc     = decode_trc(din);
    assign wr_en   = en && active && (din != SYNC_HI);
    assign wr_comp = phase_comp(phase_q);
    assign wr_data = din;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pre_q   <= PRE_IDLE;
            phase_q <= PH_CB;
            active  <= 1'b0;
            field   <= 1'b0;
            vblank  <= 1'b0;
        end else begin
            case (pre_q)
                PRE_IDLE: pre_q <= (din == SYNC_HI) ? PRE_HI : PRE_IDLE;
                PRE_HI:   pre_q <= (din == SYNC_LO) ? PRE_LO1 :
                                   (din == SYNC_HI) ? PRE_HI : PRE_IDLE;
                PRE_LO1:  pre_q <= (din == SYNC_LO) ? PRE_LO2 :
                                   (din == SYNC_HI) ? PRE_HI : PRE_IDLE;
                default:  pre_q <= PRE_IDLE;
            endcase

            if (wr_en)
                phase_q <= phase_e'(phase_q + 2'd1);

            if (active && din == SYNC_HI)
                active <= 1'b0;

            if (pre_q == PRE_LO2) begin
                field  <= trc.f;
                vblank <= trc.v;
                if (!trc.h && !trc.v) begin
                    active  <= 1'b1;
                    phase_q <= PH_CB;
                end else begin
                    active  <= 1'b0;
                end
            end
        end
    end

    AST_WRITE_IN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (active && !vblank)); // R2

    AST_FF_ENDS_LINE: assert property (@(posedge clk) disable iff (rst)
        (en && active && din == SYNC_HI) |=> !active); // R10

endmodule

// File: rtl/vcap_split_fifo.sv
module vcap_split_fifo #(
    parameter  int DEPTH = 8,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dual,
    input  logic [1:0]    wr_en,
    input  logic [15:0]   wr_data,
    input  logic [1:0]    rd_en,
    output logic [15:0]   rd_data,
    output logic [2*LW-1:0] level,
    output logic [1:0]    empty,
    output logic [1:0]    full
);

    localparam int HALF = DEPTH / 2;
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]          mem [DEPTH];
    logic [1:0]          do_w;
    logic [1:0][LW-1:0]  waddr;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [LW-1:0] wp, rp, cnt, cap, base, raddr;
        logic          do_r;

        assign cap      = (g == 0 && !dual) ? LW'(DEPTH) : LW'(HALF);
        assign base     = (g == 0) ? '0 : LW'(HALF);
        assign full[g]  = (cnt == cap);
        assign empty[g] = (cnt == '0);
        assign do_w[g]  = wr_en[g] && !full[g];
        assign do_r     = rd_en[g] && !empty[g];
        assign waddr[g] = base + wp;
        assign raddr    = base + rp;
        assign rd_data[g*8 +: 8]   = mem[raddr[PW-1:0]];
        assign level[g*LW +: LW]   = cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                wp  <= '0;
                rp  <= '0;
                cnt <= '0;
            end else begin
                if (do_w[g]) wp <= (wp == cap - 1'b1) ? '0 : wp + 1'b1;
                if (do_r)    rp <= (rp == cap - 1'b1) ? '0 : rp + 1'b1;
                cnt <= cnt + LW'(do_w[g]) - LW'(do_r);
            end
        end

        AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
            cnt <= cap); // R5

        AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
            (full[g] && wr_en[g] && !rd_en[g]) |=> (cnt == $past(cnt))); // R7

        AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
            (empty[g] && rd_en[g] && !wr_en[g]) |=> empty[g]); // R4
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < 2; g++)
            if (do_w[g]) mem[waddr[g][PW-1:0]] <= wr_data[g*8 +: 8];
    end

endmodule

// File: rtl/vcap_port.sv
module vcap_port
    import vcap_pkg::*;
#(
    parameter  int Y_DEPTH = 1280,
    localparam int C_DEPTH = Y_DEPTH / 2,
    localparam int YLW     = $clog2(Y_DEPTH + 1),
    localparam int CLW     = $clog2(C_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dual_mode,
    input  logic [7:0]       din_a,
    input  logic [7:0]       din_b,
    input  logic [1:0]       y_rd_en,
    input  logic [1:0]       cb_rd_en,
    input  logic [1:0]       cr_rd_en,
    output logic [15:0]      y_rd_data,
    output logic [15:0]      cb_rd_data,
    output logic [15:0]      cr_rd_data,
    output logic [2*YLW-1:0] y_level,
    output logic [2*CLW-1:0] cb_level,
    output logic [2*CLW-1:0] cr_level,
    output logic [1:0]       y_empty,
    output logic [1:0]       cb_empty,
    output logic [1:0]       cr_empty,
    output logic [1:0]       ovf,
    input  logic [1:0]       ovf_clr,
    output logic [1:0]       field,
    output logic [1:0]       vblank,
    output logic [1:0]       line_active
);

    logic [1:0]  lane_wr;
    comp_e       lane_comp [2];
    logic [15:0] lane_data;
    logic [1:0]  y_wr, cb_wr, cr_wr;
    logic [1:0]  y_full, cb_full, cr_full;
    logic [1:0]  drop;

    for (genvar i = 0; i < 2; i++) begin : g_chan
        vcap_lane_parser u_parser (
            .clk     (clk),
            .rst     (rst),
            .en      ((i == 0) ? 1'b1 : dual_mode),
            .din     ((i == 0) ? din_a : din_b),
            .wr_en   (lane_wr[i]),
            .wr_comp (lane_comp[i]),
            .wr_data (lane_data[i*8 +: 8]),
            .field   (field[i]),
            .vblank  (vblank[i]),
            .active  (line_active[i])
        );

        assign y_wr[i]  = lane_wr[i] && (lane_comp[i] == COMP_Y);
        assign cb_wr[i] = lane_wr[i] && (lane_comp[i] == COMP_CB);
        assign cr_wr[i] = lane_wr[i] && (lane_comp[i] == COMP_CR);
        assign drop[i]  = (y_wr[i] && y_full[i]) || (cb_wr[i] && cb_full[i]) ||
                          (cr_wr[i] && cr_full[i]);
    end

    vcap_split_fifo #(.DEPTH(Y_DEPTH)) u_y_fifo (
        .clk(clk), .rst(rst), .dual(dual_mode),
        .wr_en(y_wr), .wr_data(lane_data), .rd_en(y_rd_en),
        .rd_data(y_rd_data), .level(y_level), .empty(y_empty), .full(y_full)
    );

    vcap_split_fifo #(.DEPTH(C_DEPTH)) u_cb_fifo (
        .clk(clk), .rst(rst), .dual(dual_mode),
        .wr_en(cb_wr), .wr_data(lane_data), .rd_en(cb_rd_en),
        .rd_data(cb_rd_data), .level(cb_level), .empty(cb_empty), .full(cb_full)
    );

    vcap_split_fifo #(.DEPTH(C_DEPTH)) u_cr_fifo (
        .clk(clk), .rst(rst), .dual(dual_mode),
        .wr_en(cr_wr), .wr_data(lane_data), .rd_en(cr_rd_en),
        .rd_data(cr_rd_data), .level(cr_level), .empty(cr_empty), .full(cr_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= '0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (drop[i])         ovf[i] <= 1'b1;
                else if (ovf_clr[i]) ovf[i] <= 1'b0;
            end
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf[0] && !ovf_clr[0]) |=> ovf[0]); // R7

    AST_LANE_B_IDLE: assert property (@(posedge clk) disable iff (rst)
        !dual_mode |-> (y_empty[1] && cb_empty[1] && cr_empty[1] && !line_active[1])); // R9

endmodule

// File: tb/vcap_port_test.sv
module vcap_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int Y_DEPTH    = 8;
    localparam int YLW        = $clog2(Y_DEPTH + 1);
    localparam int CLW        = $clog2(Y_DEPTH / 2 + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             dual_mode = 1'b0;
    logic [7:0]       din_a = 8'h80, din_b = 8'h80;
    logic [1:0][2:0]  rdv = '0;
    logic [1:0]       ovf_clr = '0;
    logic [15:0]      y_rd_data, cb_rd_data, cr_rd_data;
    logic [2*YLW-1:0] y_level;
    logic [2*CLW-1:0] cb_level, cr_level;
    logic [1:0]       y_empty, cb_empty, cr_empty, ovf, field, vblank, line_active;

    vcap_port #(.Y_DEPTH(Y_DEPTH)) uut (
        .clk(clk), .rst(rst), .dual_mode(dual_mode), .din_a(din_a), .din_b(din_b),
        .y_rd_en({rdv[1][0], rdv[0][0]}), .cb_rd_en({rdv[1][1], rdv[0][1]}),
        .cr_rd_en({rdv[1][2], rdv[0][2]}),
        .y_rd_data(y_rd_data), .cb_rd_data(cb_rd_data), .cr_rd_data(cr_rd_data),
        .y_level(y_level), .cb_level(cb_level), .cr_level(cr_level),
        .y_empty(y_empty), .cb_empty(cb_empty), .cr_empty(cr_empty),
        .ovf(ovf), .ovf_clr(ovf_clr), .field(field), .vblank(vblank),
        .line_active(line_active)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int         checks = 0, errors = 0;
    bit         done = 0;
    int         cnt_m [2][3];
    logic [7:0] q [2][3][$];
    bit         ovf_m [2];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int cap(input int ch, input int comp);
        int y;
        y = (ch == 0 && !dual_mode) ? Y_DEPTH : Y_DEPTH / 2;
        return (comp == 0) ? y : y / 2;
    endfunction

    function automatic int lvl(input int ch, input int comp);
        case (comp)
            0: return int'(y_level[ch*YLW +: YLW]);
            1: return int'(cb_level[ch*CLW +: CLW]);
            default: return int'(cr_level[ch*CLW +: CLW]);
        endcase
    endfunction

    function automatic int emp(input int ch, input int comp);
        case (comp)
            0: return int'(y_empty[ch]);
            1: return int'(cb_empty[ch]);
            default: return int'(cr_empty[ch]);
        endcase
    endfunction

    function automatic int head(input int ch, input int comp);
        case (comp)
            0: return int'(y_rd_data[ch*8 +: 8]);
            1: return int'(cb_rd_data[ch*8 +: 8]);
            default: return int'(cr_rd_data[ch*8 +: 8]);
        endcase
    endfunction

    function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // driver side: expected sample into the scoreboard (R3 order Cb,Y,Cr,Y)
    task automatic push_sample(input int ch, input int k, input logic [7:0] val);
        int comp;
        comp = (k % 4 == 0) ? 1 : (k % 4 == 2) ? 2 : 0;
        if (cnt_m[ch][comp] < cap(ch, comp)) begin
            q[ch][comp].push_back(val);
            cnt_m[ch][comp]++;
        end else begin
            ovf_m[ch] = 1'b1;
        end
    endtask

    task automatic drive(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        din_a = a;
        din_b = b;
    endtask

    task automatic send_code(input logic [7:0] x);
        drive(8'hFF, 8'hFF);
        drive(8'h00, 8'h00);
        drive(8'h00, 8'h00);
        drive(x, x);
    endtask

    task automatic send_line(input logic f, input logic v, input int n,
                             input logic [7:0] sa, input logic [7:0] sb);
        send_code(xy(f, v, 1'b0));
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0) begin
                chk("R2", "line_active A", int'(line_active[0]), int'(!v));
                chk("R9", "line_active B", int'(line_active[1]), int'(dual_mode && !v));
            end
            din_a = sa + 8'(k);
            din_b = sb + 8'(k);
            if (!v) begin
                push_sample(0, k, sa + 8'(k));
                if (dual_mode) push_sample(1, k, sb + 8'(k));
            end
        end
        send_code(xy(f, v, 1'b1));
        drive(8'h80, 8'h80);
        @(negedge clk);
        chk("R8", "field A", int'(field[0]), int'(f));
        chk("R8", "vblank A", int'(vblank[0]), int'(v));
        chk("R2", "line_active A after end", int'(line_active[0]), 0);
        if (dual_mode) chk("R8", "field B", int'(field[1]), int'(f));
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        for (int ch = 0; ch < 2; ch++) begin
            for (int comp = 0; comp < 3; comp++) begin
                chk(req, $sformatf("level ch%0d comp%0d", ch, comp), lvl(ch, comp), cnt_m[ch][comp]);
                chk(req, $sformatf("empty ch%0d comp%0d", ch, comp), emp(ch, comp),
                    int'(cnt_m[ch][comp] == 0));
            end
            chk("R7", $sformatf("ovf ch%0d", ch), int'(ovf[ch]), int'(ovf_m[ch]));
        end
    endtask

    // monitor side: pop the design's queues and compare with the scoreboard
    task automatic drain();
        for (int ch = 0; ch < 2; ch++)
            for (int comp = 0; comp < 3; comp++)
                while (q[ch][comp].size() > 0) begin
                    @(negedge clk);
                    rdv = '0;
                    chk("R4", $sformatf("head ch%0d comp%0d", ch, comp), head(ch, comp),
                        int'(q[ch][comp].pop_front()));
                    rdv[ch][comp] = 1'b1;
                    cnt_m[ch][comp]--;
                end
        @(negedge clk);
        rdv = '0;
    endtask

    task automatic clear_ovf(input logic [1:0] m);
        @(negedge clk);
        ovf_clr = m;
        @(negedge clk);
        ovf_clr = '0;
        for (int ch = 0; ch < 2; ch++) if (m[ch]) ovf_m[ch] = 1'b0;
    endtask

    task automatic do_reset(input logic dual);
        @(negedge clk);
        rst = 1'b1;
        dual_mode = dual;
        din_a = 8'h80;
        din_b = 8'h80;
        for (int ch = 0; ch < 2; ch++) begin
            ovf_m[ch] = 1'b0;
            for (int comp = 0; comp < 3; comp++) begin
                cnt_m[ch][comp] = 0;
                q[ch][comp].delete();
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11 reset state
        do_reset(1'b0);
        check_all("R11");
        chk("R11", "field", int'(field), 0);
        chk("R11", "vblank", int'(vblank), 0);
        chk("R11", "line_active", int'(line_active), 0);

        // R4 read of an empty queue is ignored
        @(negedge clk);
        rdv[0] = 3'b111;
        @(negedge clk);
        rdv = '0;
        check_all("R4");

        // R1/R3/R5 basic single-channel line
        send_line(1'b0, 1'b0, 4, 8'h10, 8'h50);
        check_all("R3");
        drain();
        check_all("R4");

        // R2/R8 blanked line: nothing stored, field and vblank follow the code
        send_line(1'b1, 1'b1, 8, 8'h20, 8'h60);
        check_all("R2");

        // R10 a 0xFF inside active video ends capture
        send_code(xy(1'b0, 1'b0, 1'b0));
        drive(8'h40, 8'h40);
        push_sample(0, 0, 8'h40);
        drive(8'h41, 8'h41);
        push_sample(0, 1, 8'h41);
        drive(8'hFF, 8'hFF);
        drive(8'h42, 8'h42);
        drive(8'h43, 8'h43);
        drive(8'h80, 8'h80);
        @(negedge clk);
        chk("R10", "line_active after 0xFF", int'(line_active[0]), 0);
        check_all("R10");
        drain();

        // R5 fill to capacity, R7 overflow, R9 lane B ignored
        send_line(1'b0, 1'b0, 16, 8'h10, 8'h50);
        check_all("R5");
        chk("R7", "no ovf at exact capacity", int'(ovf[0]), 0);
        send_line(1'b0, 1'b0, 4, 8'hA0, 8'hB0);
        check_all("R7");
        chk("R7", "ovf set", int'(ovf[0]), 1);
        clear_ovf(2'b01);
        check_all("R7");
        drain();
        check_all("R9");

        // R6 dual-channel mode: half capacity, independent channels
        do_reset(1'b1);
        send_line(1'b1, 1'b0, 8, 8'h10, 8'h60);
        check_all("R6");
        send_line(1'b1, 1'b0, 4, 8'hA0, 8'hC0);
        check_all("R6");
        chk("R6", "both channels overflowed", int'(ovf), 3);
        clear_ovf(2'b10);
        check_all("R6");
        chk("R6", "only channel B cleared", int'(ovf), 1);
        drain();
        check_all("R6");
        send_line(1'b0, 1'b0, 4, 8'h30, 8'h70);
        check_all("R6");
        drain();

        finish_run();
    end

endmodule